// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is the slave side of a three-wire configuration port: a serial clock, an active-low load strobe and a data line that the block drives back only while it answers a read. The host lowers the strobe, clocks in a frame (one direction flag, a 3-bit register address, then up to ten data bits, least significant first), and raises the strobe. A write takes effect on that rising strobe edge. A read returns the stored word bit by bit during the data phase of the same frame.

The port, strobe and data pins are oversampled in the block's own clock domain. The stored registers are presented as decoded parallel fields: operating mode, output mode, clock polarity, power-down mode, clamp-level select with its decoded black-level target, a 10-bit gain, two 8-bit DAC codes, an offset-correction enable, a gain-source select and a DAC enable. Downstream logic consumes these fields directly.

Top module: `ser_cfg_port`

## Requirements
- R1: Frame bit order on rising serial clock edges is flag (0 = write, 1 = read), address A0, A1, A2, then D0..D9. The address value {A2,A1,A0} selects a register: 1 = mode, 2 = 10-bit gain, 3 = DAC1 code (D7..D0), 4 = DAC2 code (D7..D0), 5 = second mode register.
- R2: After reset, operating mode is 2'b11 and every other stored bit is 0. The mode register therefore reads 10'h003, and the offset-correction enable output is 1.
- R3: Serial clock edges past the 14th in a frame are ignored, so a 16- or 20-edge frame acts like a 14-edge frame.
- R4: Stored values change only on the rising load strobe. A write frame with fewer than 14 edges is dropped, except the short gain write in R5.
- R5: When operating mode is 2'b01 (auxiliary), a 12-edge write to the gain register loads its 8 data bits into gain[9:2] and clears gain[1:0]. In any other mode such a frame is dropped. A full 14-edge gain write works in every mode.
- R6: In a read frame, the data-line enable is high only after the 4th through the 13th rising edge. After edge 4+k it presents bit k of the addressed register, and a read changes no register.
- R7: Writes to addresses 0, 6 and 7 are dropped, and reads from them return 0.
- R8: In the second mode register, D0 = 1 disables offset correction (enable output = !D0), D2 = 1 selects internal gain control, and D3 = 1 turns the DACs on. D1 is not stored and reads back as 0.
- R9: Mode register layout: [1:0] operating mode, [3:2] power-down (00 normal, 01 high-speed auxiliary, 10 reference standby, 11 shutdown), [5:4] clamp select, [7:6] clock polarity, [9:8] output mode. Clamp select 00/01/10/11 decodes to targets 32/48/64/16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| sl_i | input | 1 | Load strobe, low during a frame |
| sdata_i | input | 1 | Serial data from host |
| sdata_o | output | 1 | Serial read data to host |
| sdata_oe_o | output | 1 | Drive enable for the data line |
| op_mode_o | output | 2 | Operating mode |
| out_mode_o | output | 2 | Output mode |
| clk_pol_o | output | 2 | Clock / clamp pulse polarity |
| pd_mode_o | output | 2 | Power-down mode |
| clamp_sel_o | output | 2 | Clamp level select |
| clamp_level_o | output | 7 | Decoded black-level target in LSB |
| gain_o | output | 10 | Gain code |
| dac1_o | output | 8 | DAC1 code |
| dac2_o | output | 8 | DAC2 code |
| ofs_corr_en_o | output | 1 | Offset correction enable |
| gain_int_o | output | 1 | Internal gain control select |
| dac_on_o | output | 1 | DACs operational |

## Verification
The bench drives frames with trailing dummy edges to show that a port which kept counting past 14 would shift garbage into the data word. It drives truncated frames, where a design that committed on any strobe edge would store partial words. Short 8-bit gain writes are exercised both in and out of auxiliary mode, which exposes a design that misaligns the field into gain[7:0] or accepts the short form everywhere. Reads check the enable window edge by edge, so a one-edge offset in the data phase shows up, and they target undefined addresses and the reserved D1 bit of the second mode register.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int FRAME_BITS = 14;
  localparam int HDR_BITS   = 4;
  localparam int DATA_BITS  = FRAME_BITS - HDR_BITS;
  localparam int SHORT_BITS = 8;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [2:0] ADDR_MODE  = 3'd1;
  localparam logic [2:0] ADDR_GAIN  = 3'd2;
  localparam logic [2:0] ADDR_DAC1  = 3'd3;
  localparam logic [2:0] ADDR_DAC2  = 3'd4;
  localparam logic [2:0] ADDR_MODE2 = 3'd5;

  localparam logic [1:0] OP_AUX = 2'b01;
  localparam logic [DATA_BITS-1:0] MODE_RST = 10'h003;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sl_i,
  input  logic sd_i,
  output logic sck_rise_o,
  output logic sl_rise_o,
  output logic sl_o,
  output logic sd_o
);
  // bit order {sd, sl, sck}; strobe idles high
  localparam logic [2:0] IDLE = 3'b010;

  logic [STAGES-1:0][2:0] stg_q;
  logic [1:0]             prev_q;
  logic [2:0]             cur;

  assign cur = stg_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= {STAGES{IDLE}};
      prev_q <= IDLE[1:0];
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stg_q[s] <= stg_q[s-1];
      stg_q[0] <= {sd_i, sl_i, sck_i};
      prev_q   <= cur[1:0];
    end
  end

  assign sck_rise_o = cur[0] & ~prev_q[0];
  assign sl_rise_o  = cur[1] & ~prev_q[1];
  assign sl_o       = cur[1];
  assign sd_o       = cur[2];
endmodule

// File: rtl/ser_frame.sv
module ser_frame
  import ser_cfg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sck_rise_i,
  input  logic                 sl_i,
  input  logic                 sd_i,
  input  logic [DATA_BITS-1:0] rd_word_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 rnw_o,
  output logic [2:0]           addr_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 sd_o,
  output logic                 oe_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] HDR  = CNT_W'(HDR_BITS);

  logic [CNT_W-1:0]     cnt_q;
  logic                 rnw_q;
  logic [2:0]           addr_q;
  logic [DATA_BITS-1:0] data_q;
  logic [CNT_W-1:0]     ridx;
  logic [DATA_BITS-1:0] rd_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rnw_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (sl_i) begin
      cnt_q  <= '0;
      rnw_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (sck_rise_i && cnt_q < LAST) begin
      if (cnt_q == '0)     rnw_q <= sd_i;
      else if (cnt_q < HDR) addr_q[cnt_q[1:0] - 2'd1] <= sd_i;
      else                 data_q[cnt_q - HDR] <= sd_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // read data phase: bit k after edge HDR+k
  assign ridx  = cnt_q - HDR;
  assign rd_sh = rd_word_i >> ridx;
  assign oe_o  = rnw_q && !sl_i && cnt_q >= HDR && cnt_q < LAST;
  assign sd_o  = oe_o & rd_sh[0];

  assign cnt_o  = cnt_q;
  assign rnw_o  = rnw_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/ser_bank.sv
module ser_bank
  import ser_cfg_pkg::*;
#(
  parameter int DAC_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic                 rnw_i,
  input  logic [2:0]           addr_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic [DATA_BITS-1:0] mode_o,
  output logic [DATA_BITS-1:0] gain_o,
  output logic [DAC_W-1:0]     dac1_o,
  output logic [DAC_W-1:0]     dac2_o,
  output logic [2:0]           mode2_o,
  output logic [DATA_BITS-1:0] rd_word_o
);
  localparam int PAD = DATA_BITS - DAC_W;
  localparam int LOW = DATA_BITS - SHORT_BITS;

  logic [DATA_BITS-1:0] mode_q, gain_q;
  logic [DAC_W-1:0]     dac1_q, dac2_q;
  logic [2:0]           m2_q;   // {dac_on, gain_int, ofs_dis}
  logic                 wr_full, wr_short;

  assign wr_full  = commit_i && !rnw_i && cnt_i == CNT_W'(FRAME_BITS);
  assign wr_short = commit_i && !rnw_i && cnt_i == CNT_W'(HDR_BITS + SHORT_BITS)
                    && addr_i == ADDR_GAIN && mode_q[1:0] == OP_AUX;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      gain_q <= '0;
      dac1_q <= '0;
      dac2_q <= '0;
      m2_q   <= '0;
    end else if (wr_short) begin
      gain_q <= {data_i[SHORT_BITS-1:0], {LOW{1'b0}}};
    end else if (wr_full) begin
      case (addr_i)
        ADDR_MODE:  mode_q <= data_i;
        ADDR_GAIN:  gain_q <= data_i;
        ADDR_DAC1:  dac1_q <= data_i[DAC_W-1:0];
        ADDR_DAC2:  dac2_q <= data_i[DAC_W-1:0];
        ADDR_MODE2: m2_q   <= {data_i[3], data_i[2], data_i[0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_MODE:  rd_word_o = mode_q;
      ADDR_GAIN:  rd_word_o = gain_q;
      ADDR_DAC1:  rd_word_o = {{PAD{1'b0}}, dac1_q};
      ADDR_DAC2:  rd_word_o = {{PAD{1'b0}}, dac2_q};
      ADDR_MODE2: rd_word_o = {6'b0, m2_q[2], m2_q[1], 1'b0, m2_q[0]};
      default:    rd_word_o = '0;
    endcase
  end

  assign mode_o  = mode_q;
  assign gain_o  = gain_q;
  assign dac1_o  = dac1_q;
  assign dac2_o  = dac2_q;
  assign mode2_o = m2_q;
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DAC_W       = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sck_i,
  input  logic                 sl_i,
  input  logic                 sdata_i,
  output logic                 sdata_o,
  output logic                 sdata_oe_o,
  output logic [1:0]           op_mode_o,
  output logic [1:0]           out_mode_o,
  output logic [1:0]           clk_pol_o,
  output logic [1:0]           pd_mode_o,
  output logic [1:0]           clamp_sel_o,
  output logic [6:0]           clamp_level_o,
  output logic [DATA_BITS-1:0] gain_o,
  output logic [DAC_W-1:0]     dac1_o,
  output logic [DAC_W-1:0]     dac2_o,
  output logic                 ofs_corr_en_o,
  output logic                 gain_int_o,
  output logic                 dac_on_o
);
  logic                 sck_rise, sl_rise, sl_lvl, sd_lvl;
  logic [CNT_W-1:0]     cnt;
  logic                 rnw;
  logic [2:0]           addr;
  logic [DATA_BITS-1:0] data, rd_word, mode;
  logic [2:0]           mode2;

  ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .sl_i, .sd_i(sdata_i),
    .sck_rise_o(sck_rise), .sl_rise_o(sl_rise), .sl_o(sl_lvl), .sd_o(sd_lvl)
  );

  ser_frame u_frame (
    .clk_i, .rst_ni, .sck_rise_i(sck_rise), .sl_i(sl_lvl), .sd_i(sd_lvl),
    .rd_word_i(rd_word), .cnt_o(cnt), .rnw_o(rnw), .addr_o(addr), .data_o(data),
    .sd_o(sdata_o), .oe_o(sdata_oe_o)
  );

  ser_bank #(.DAC_W(DAC_W)) u_bank (
    .clk_i, .rst_ni, .commit_i(sl_rise), .rnw_i(rnw), .addr_i(addr), .cnt_i(cnt),
    .data_i(data), .mode_o(mode), .gain_o(gain_o), .dac1_o(dac1_o), .dac2_o(dac2_o),
    .mode2_o(mode2), .rd_word_o(rd_word)
  );

  assign op_mode_o     = mode[1:0];
  assign pd_mode_o     = mode[3:2];
  assign clamp_sel_o   = mode[5:4];
  assign clk_pol_o     = mode[7:6];
  assign out_mode_o    = mode[9:8];
  assign ofs_corr_en_o = ~mode2[0];
  assign gain_int_o    = mode2[1];
  assign dac_on_o      = mode2[2];

  always_comb begin
    case (clamp_sel_o)
      2'b00:   clamp_level_o = 7'd32;
      2'b01:   clamp_level_o = 7'd48;
      2'b10:   clamp_level_o = 7'd64;
      default: clamp_level_o = 7'd16;
    endcase
  end
endmodule

// File: rtl/ser_cfg_chk.sv
module ser_cfg_chk
  import ser_cfg_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sck_rise,
  input logic                 sl_rise,
  input logic                 sl_lvl,
  input logic [CNT_W-1:0]     cnt,
  input logic                 rnw,
  input logic [2:0]           addr,
  input logic                 sdata_oe_o,
  input logic [1:0]           op_mode_o,
  input logic [6:0]           clamp_level_o,
  input logic [DATA_BITS-1:0] gain_o,
  input logic [7:0]           dac1_o,
  input logic [7:0]           dac2_o
);
  assert_cnt_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(FRAME_BITS));

  assert_cnt_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(FRAME_BITS) && !sl_lvl) |=> cnt == CNT_W'(FRAME_BITS));

  assert_idle_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sl_lvl |=> cnt == '0);

  assert_commit_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sl_rise |=> ($stable(gain_o) && $stable(dac1_o) && $stable(dac2_o) && $stable(op_mode_o)));

  assert_oe_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdata_oe_o) |-> $past(sck_rise));

  assert_oe_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> (rnw && !sl_rise));

  assert_short_gain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_rise && !rnw && cnt == CNT_W'(HDR_BITS + SHORT_BITS) && addr == ADDR_GAIN
     && op_mode_o == OP_AUX) |=> gain_o[1:0] == 2'b00);

  assert_clamp_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_level_o inside {7'd16, 7'd32, 7'd48, 7'd64});
endmodule

bind ser_cfg_port ser_cfg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_rise(sck_rise), .sl_rise(sl_rise), .sl_lvl(sl_lvl),
  .cnt(cnt), .rnw(rnw), .addr(addr), .sdata_oe_o(sdata_oe_o), .op_mode_o(op_mode_o),
  .clamp_level_o(clamp_level_o), .gain_o(gain_o), .dac1_o(dac1_o), .dac2_o(dac2_o)
);

// File: tb/sim_ser_cfg_port.sv
`timescale 1ns/1ps
module sim_ser_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, sl = 1'b1, sd = 1'b0;
  logic       sdata_o, sdata_oe_o, ofs_corr_en_o, gain_int_o, dac_on_o;
  logic [1:0] op_mode_o, out_mode_o, clk_pol_o, pd_mode_o, clamp_sel_o;
  logic [6:0] clamp_level_o;
  logic [9:0] gain_o;
  logic [7:0] dac1_o, dac2_o;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ser_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sl_i(sl), .sdata_i(sd),
    .sdata_o, .sdata_oe_o, .op_mode_o, .out_mode_o, .clk_pol_o, .pd_mode_o,
    .clamp_sel_o, .clamp_level_o, .gain_o, .dac1_o, .dac2_o,
    .ofs_corr_en_o, .gain_int_o, .dac_on_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // nb = number of serial edges; edges past 14 carry dummy ones
  task automatic frame(input logic rnw, input logic [2:0] a, input logic [9:0] d,
                       input int nb, output logic [9:0] rd, output int oe_bad,
                       output logic [25:0] pre);
    logic b;
    rd = '0; oe_bad = 0;
    @(negedge clk) sl = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (i == 0)      b = rnw;
      else if (i < 4)  b = a[i-1];
      else if (i < 14) b = d[i-4];
      else             b = 1'b1;
      sd = b;
      repeat (8) @(negedge clk);
      if (sdata_oe_o !== (rnw && i >= 4 && i < 14)) oe_bad++;
      if (i >= 4 && i < 14) rd[i-4] = sdata_o;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    pre = {gain_o, dac1_o, dac2_o};
    sl = 1'b1;
    repeat (12) @(negedge clk);
    if (sdata_oe_o !== 1'b0) oe_bad++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [9:0] d, input int nb, input string tag);
    logic [9:0] rd; int bad; logic [25:0] pre;
    frame(1'b0, a, d, nb, rd, bad, pre);
    chk({tag, " write frame enable"}, bad, 0);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [9:0] exp, input string tag);
    logic [9:0] rd; int bad; logic [25:0] pre;
    frame(1'b1, a, 10'h0, 14, rd, bad, pre);
    chk({tag, " read data"}, rd, exp);
    chk({tag, " read enable window"}, bad, 0);
  endtask

  task automatic t_reset;
    chk("R2 op mode", op_mode_o, 2'b11);
    chk("R2 gain", gain_o, 0);
    chk("R2 dacs", {dac1_o, dac2_o}, 0);
    chk("R2 fields", {out_mode_o, clk_pol_o, pd_mode_o, clamp_sel_o}, 0);
    chk("R2 mode2 outs", {ofs_corr_en_o, gain_int_o, dac_on_o}, 3'b100);
    chk("R2 R9 clamp target", clamp_level_o, 32);
    chk("R2 oe idle", sdata_oe_o, 0);
    rd_chk(3'd1, 10'h003, "R2 mode readback");
  endtask

  task automatic t_write_read;
    wr(3'd2, 10'h2A5, 14, "R1");
    wr(3'd3, 10'h05C, 14, "R1");
    wr(3'd4, 10'h0A3, 14, "R1");
    chk("R1 gain", gain_o, 10'h2A5);
    chk("R1 dac1", dac1_o, 8'h5C);
    chk("R1 dac2", dac2_o, 8'hA3);
    rd_chk(3'd2, 10'h2A5, "R6 gain");
    rd_chk(3'd3, 10'h05C, "R6 dac1");
    rd_chk(3'd4, 10'h0A3, "R6 dac2");
    chk("R6 read leaves regs", {gain_o, dac1_o, dac2_o}, {10'h2A5, 8'h5C, 8'hA3});
  endtask

  task automatic t_mode_fields;
    wr(3'd1, 10'h1E6, 14, "R9");
    chk("R9 op", op_mode_o, 2'b10);
    chk("R9 pd", pd_mode_o, 2'b01);
    chk("R9 clamp sel", clamp_sel_o, 2'b10);
    chk("R9 clk pol", clk_pol_o, 2'b11);
    chk("R9 out mode", out_mode_o, 2'b01);
    for (int c = 0; c < 4; c++) begin
      logic [6:0] exp_lvl;
      exp_lvl = (c == 3) ? 7'd16 : 7'(32 + 16 * c);
      wr(3'd1, 10'(c << 4) | 10'h002, 14, "R9");
      chk("R9 clamp decode", clamp_level_o, exp_lvl);
    end
  endtask

  task automatic t_extra_edges;
    wr(3'd3, 10'h033, 16, "R3");
    chk("R3 16-edge frame", dac1_o, 8'h33);
    wr(3'd4, 10'h0C5, 20, "R3");
    chk("R3 20-edge frame", dac2_o, 8'hC5);
    rd_chk(3'd4, 10'h0C5, "R3 readback");
  endtask

  task automatic t_commit;
    logic [9:0] rd; int bad; logic [25:0] pre;
    frame(1'b0, 3'd3, 10'h0E1, 14, rd, bad, pre);
    chk("R4 no change before strobe", pre[15:8], 8'h33);
    chk("R4 change after strobe", dac1_o, 8'hE1);
    wr(3'd4, 10'h011, 10, "R4");
    chk("R4 short frame dropped", dac2_o, 8'hC5);
    wr(3'd2, 10'h3FF, 13, "R4");
    chk("R4 13-edge gain dropped", gain_o, 10'h2A5);
  endtask

  task automatic t_aux_gain;
    wr(3'd1, 10'h001, 14, "R5");
    chk("R5 aux mode set", op_mode_o, 2'b01);
    wr(3'd2, 10'h0B7, 12, "R5");
    chk("R5 short gain in aux", gain_o, 10'h2DC);
    wr(3'd2, 10'h155, 14, "R5");
    chk("R5 full gain in aux", gain_o, 10'h155);
    wr(3'd1, 10'h002, 14, "R5");
    wr(3'd2, 10'h011, 12, "R5");
    chk("R5 short gain outside aux", gain_o, 10'h155);
  endtask

  task automatic t_undefined;
    wr(3'd0, 10'h3FF, 14, "R7");
    wr(3'd6, 10'h3FF, 14, "R7");
    wr(3'd7, 10'h3FF, 14, "R7");
    chk("R7 regs kept", {gain_o, dac1_o, dac2_o}, {10'h155, 8'hE1, 8'hC5});
    chk("R7 mode kept", {out_mode_o, clk_pol_o, pd_mode_o, clamp_sel_o, op_mode_o}, 10'h002);
    chk("R7 mode2 kept", {ofs_corr_en_o, gain_int_o, dac_on_o}, 3'b100);
    rd_chk(3'd6, 10'h000, "R7 read 6");
    rd_chk(3'd0, 10'h000, "R7 read 0");
  endtask

  task automatic t_mode2;
    wr(3'd5, 10'h00F, 14, "R8");
    chk("R8 outs set", {ofs_corr_en_o, gain_int_o, dac_on_o}, 3'b011);
    rd_chk(3'd5, 10'h00D, "R8 reserved bit");
    wr(3'd5, 10'h002, 14, "R8");
    chk("R8 outs cleared", {ofs_corr_en_o, gain_int_o, dac_on_o}, 3'b100);
    rd_chk(3'd5, 10'h000, "R8 only reserved");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_mode_fields();
    t_extra_edges();
    t_commit();
    t_aux_gain();
    t_undefined();
    t_mode2();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule